// File: doc/BRIEF.md
# Flash Write-Gate Window Timer

This block drives the write-enable gate of a parallel flash device. A requester arms the gate by writing a control word whose bit 0 is set. The gate then opens for a fixed window of `WIN_CYC` clock cycles and shuts again without further action. A settling interval of `SET_CYC` cycles must elapse after each arming before the flash path may rely on the gate. When that interval ends, a one-cycle ready strobe tells the requester to go ahead. Every flash command write needs its own arming, so the requester arms once per command and waits for the strobe each time.

The block also guards the gate. Any flash write attempted while the gate is shut sets a sticky flag and increments a saturating counter. Bit 1 of the same control word clears both; it is write-one-to-clear. The other control bits have no effect, so a shared control word can carry unrelated fields.

The controller has four states:
- CLOSED: gate shut.
- SETTLING: gate open, settle count running.
- READY: gate open, ready strobe high for one cycle.
- OPEN: gate open, waiting for the window to run out.

The transitions are:
- ARM: from any state to SETTLING on an arming write.
- SETTLED: from SETTLING to READY when the settle count reaches zero.
- STROBED: from READY to OPEN on the following cycle.
- EXPIRE: from SETTLING, READY or OPEN to CLOSED when the window count reaches zero.

ARM has priority over EXPIRE, and EXPIRE has priority over SETTLED.

Top module: `flash_wgate_timer`

## Requirements
- R1: After reset `gate_open` and `gate_ready` are low, `blk_flag` is low and `blk_count` is zero.
- R2: A control write with bit 0 set opens the gate in the cycle after the write. A control write with bit 0 clear does not open it, and bits above 1 of the control word are ignored.
- R3: Once armed and not re-armed, `gate_open` stays high for exactly `WIN_CYC` cycles and then falls by itself.
- R4: `gate_ready` pulses high for exactly one cycle, `SET_CYC` cycles after the arming write's clock edge, and only while the gate is open.
- R5: An arming write while the gate is open restarts both the full window and the settle interval, and a new ready strobe follows.
- R6: A flash write (`flash_wr`) in a cycle where `gate_open` is low sets `blk_flag`. The flag stays set until it is cleared.
- R7: `blk_count` counts blocked flash writes and saturates at its maximum of 2^`CNT_W`-1 without wrapping.
- R8: A control write with bit 1 set clears `blk_flag` and `blk_count`. If a blocked flash write occurs in the same cycle, the result is flag high and count one.
- R9: Flash writes made while `gate_open` is high leave `blk_flag` and `blk_count` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | CTL_W | Control word: bit 0 arms the gate, bit 1 clears the blocked-write record |
| flash_wr | input | 1 | Flash write attempt on the gated path |
| gate_open | output | 1 | Write gate open level to the flash write-enable path |
| gate_ready | output | 1 | One-cycle strobe when the settle interval has elapsed |
| blk_flag | output | 1 | Sticky record of a write attempted while the gate was shut |
| blk_count | output | CNT_W | Saturating count of blocked writes |

## Verification
Every result here comes from a state register, so timing is counted from the clock edge that samples a stimulus:
- `gate_open` and the blocked-write record change at that edge itself.
- `gate_ready` rises `SET_CYC` edges after the arming edge.
- `gate_open` falls `WIN_CYC` edges after the arming edge.

The bench drives inputs on the falling edge and advances its behavioural model on the rising edge. It compares all four outputs on the next falling edge, so every result is sampled half a cycle after the edge that is due to produce it.

// File: rtl/wg_pkg.sv
package wg_pkg;
    typedef enum logic [1:0] {
        ST_CLOSED   = 2'd0,
        ST_SETTLING = 2'd1,
        ST_READY    = 2'd2,
        ST_OPEN     = 2'd3
    } wg_state_e;

    localparam int ARM_BIT = 0;
    localparam int CLR_BIT = 1;
endpackage

// File: rtl/wg_down_counter.sv
module wg_down_counter #(
    parameter int WIDTH    = 8,
    parameter int LOAD_VAL = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic en,
    output logic zero
);
    logic [WIDTH-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= WIDTH'(LOAD_VAL);
        end else if (en && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);

    // a load always leaves the programmed value for the next cycle (supports R3/R4 timing)
    p_load_value_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt == WIDTH'(LOAD_VAL)));
endmodule

// File: rtl/wg_blocked_log.sv
module wg_blocked_log #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             blocked,
    input  logic             clear,
    output logic             flag,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag  <= 1'b0;
            count <= '0;
        end else if (clear) begin
            flag  <= blocked;
            count <= blocked ? CNT_W'(1) : '0;
        end else if (blocked) begin
            flag <= 1'b1;
            if (count != CNT_MAX) begin
                count <= count + 1'b1;
            end
        end
    end

    p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clear) |=> flag);

    p_no_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CNT_MAX && !clear) |=> (count == CNT_MAX));

    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && !blocked) |=> (!flag && count == '0));
endmodule

// File: rtl/flash_wgate_timer.sv
module flash_wgate_timer
    import wg_pkg::*;
#(
    parameter int WIN_CYC = 200000,
    parameter int SET_CYC = 2500,
    parameter int CTL_W   = 8,
    parameter int CNT_W   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  logic             flash_wr,
    output logic             gate_open,
    output logic             gate_ready,
    output logic             blk_flag,
    output logic [CNT_W-1:0] blk_count
);
    localparam int WIN_W = $clog2(WIN_CYC + 1);
    localparam int SET_W = $clog2(SET_CYC + 1);

    wg_state_e state, state_nx;
    logic      arm, clr, blocked;
    logic      win_zero, set_zero;

    assign arm = ctl_wr & ctl_wdata[ARM_BIT];
    assign clr = ctl_wr & ctl_wdata[CLR_BIT];

    logic unused_ctl;
    assign unused_ctl = ^ctl_wdata;

    // window counter runs in every open state
    wg_down_counter #(.WIDTH(WIN_W), .LOAD_VAL(WIN_CYC - 1)) i_win_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .load (arm),
        .en   (state != ST_CLOSED),
        .zero (win_zero)
    );

    // settle counter runs only while settling
    wg_down_counter #(.WIDTH(SET_W), .LOAD_VAL(SET_CYC - 1)) i_set_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .load (arm),
        .en   (state == ST_SETTLING),
        .zero (set_zero)
    );

    // next-state logic: ARM > EXPIRE > SETTLED / STROBED
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_CLOSED: begin
                if (arm) state_nx = ST_SETTLING;
            end
            ST_SETTLING: begin
                if (arm)           state_nx = ST_SETTLING;
                else if (win_zero) state_nx = ST_CLOSED;
                else if (set_zero) state_nx = ST_READY;
            end
            ST_READY: begin
                if (arm)           state_nx = ST_SETTLING;
                else if (win_zero) state_nx = ST_CLOSED;
                else               state_nx = ST_OPEN;
            end
            ST_OPEN: begin
                if (arm)           state_nx = ST_SETTLING;
                else if (win_zero) state_nx = ST_CLOSED;
            end
            default: state_nx = ST_CLOSED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_CLOSED;
        else        state <= state_nx;
    end

    // outputs
    always_comb begin
        gate_open  = 1'b0;
        gate_ready = 1'b0;
        unique case (state)
            ST_CLOSED:   ;
            ST_SETTLING: gate_open = 1'b1;
            ST_READY: begin
                gate_open  = 1'b1;
                gate_ready = 1'b1;
            end
            ST_OPEN:     gate_open = 1'b1;
            default:     ;
        endcase
    end

    assign blocked = flash_wr & ~gate_open;

    wg_blocked_log #(.CNT_W(CNT_W)) i_blk_log (
        .clk  (clk),
        .rst_n(rst_n),
        .blocked(blocked),
        .clear(clr),
        .flag (blk_flag),
        .count(blk_count)
    );

    p_arm_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> (gate_open && !gate_ready));

    p_close_on_expiry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gate_open) |-> $past(win_zero));

    p_ready_open_r4: assert property (@(posedge clk) disable iff (!rst_n)
        gate_ready |-> gate_open);

    p_ready_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        gate_ready |=> !gate_ready);

    p_rearm_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && gate_open) |=> (gate_open && !win_zero || WIN_CYC == 1));

    p_open_no_record_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_open && !clr) |=> $stable(blk_count));
endmodule

// File: tb/test_flash_wgate_timer.sv
module test_flash_wgate_timer;
    localparam int W    = 40;
    localparam int S    = 5;
    localparam int CW   = 3;
    localparam int MAXC = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ctl_wr = 1'b0;
    logic [7:0]    ctl_wdata = '0;
    logic          flash_wr = 1'b0;
    logic          gate_open, gate_ready, blk_flag;
    logic [CW-1:0] blk_count;

    int    checks = 0;
    int    errors = 0;
    int    cycles = 0;
    string cur_req = "R1";

    // reference model state
    bit m_armed = 0;
    int m_age   = 0;
    bit m_flag  = 0;
    int m_cnt   = 0;

    always #5 clk = ~clk;

    flash_wgate_timer #(.WIN_CYC(W), .SET_CYC(S), .CTL_W(8), .CNT_W(CW)) i_flash_wgate_timer (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .flash_wr(flash_wr), .gate_open(gate_open), .gate_ready(gate_ready),
        .blk_flag(blk_flag), .blk_count(blk_count)
    );

    always @(posedge clk) begin
        bit open_now, blk;
        if (!rst_n) begin
            m_armed = 0; m_age = 0; m_flag = 0; m_cnt = 0;
        end else begin
            open_now = m_armed && m_age < W;
            blk = flash_wr && !open_now;
            if (ctl_wr && ctl_wdata[1]) begin
                m_flag = blk;
                m_cnt  = blk ? 1 : 0;
            end else if (blk) begin
                m_flag = 1;
                if (m_cnt < MAXC) m_cnt++;
            end
            if (ctl_wr && ctl_wdata[0]) begin
                m_armed = 1; m_age = 0;
            end else if (m_armed) begin
                m_age++;
                if (m_age >= W) m_armed = 0;
            end
        end
    end

    task automatic cmp(string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", cur_req, what, act, exp, cycles);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        cmp("gate_open",  int'(gate_open),  int'(m_armed && m_age < W));
        cmp("gate_ready", int'(gate_ready), int'(m_armed && m_age == S && S < W));
        cmp("blk_flag",   int'(blk_flag),   int'(m_flag));
        cmp("blk_count",  int'(blk_count),  m_cnt);
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
        ctl_wr = 0; flash_wr = 0;
    endtask

    task automatic ctl(logic [7:0] d, logic fw);
        @(negedge clk);
        ctl_wr = 1; ctl_wdata = d; flash_wr = fw;
        @(negedge clk);
        ctl_wr = 0; ctl_wdata = '0; flash_wr = 0;
    endtask

    task automatic fwrites(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            flash_wr = 1;
        end
        @(negedge clk);
        flash_wr = 0;
    endtask

    initial begin
        cur_req = "R1";
        idle(4);
        @(negedge clk); rst_n = 1;
        idle(3);
        cur_req = "R6";  fwrites(2); idle(6);
        cur_req = "R7";  fwrites(9); idle(3);
        cur_req = "R8";  ctl(8'h02, 1'b0); idle(2);
        fwrites(3);
        ctl(8'hFE, 1'b1); idle(3);
        cur_req = "R2";  ctl(8'hFC, 1'b0); idle(4);
        ctl(8'h01, 1'b0);
        cur_req = "R4";  idle(8);
        cur_req = "R3";  idle(40);
        cur_req = "R9";  ctl(8'hFD, 1'b0); fwrites(10); idle(40);
        cur_req = "R5";  ctl(8'h01, 1'b0); idle(20);
        ctl(8'h01, 1'b1); idle(3);
        ctl(8'h03, 1'b0); idle(50);
        cur_req = "R6";  fwrites(1); idle(5);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule